// File: doc/BRIEF.md
# Low-Transition Test Pattern Inserter

This block drives test patterns toward a circuit under test while holding down the number of bits that toggle from one applied pattern to the next. It contains a small linear feedback shift register, whose feedback taps and nonzero seed are parameters. Between two consecutive register values T_i and T_i+1 it emits two intermediate patterns. The first is a half-fixed pattern: the upper half is kept from T_i and the lower half is taken from T_i+1. The second is the half-fixed pattern with one designated bit of the upper half replaced by its value in T_i+1. The full T_i+1 then follows.

A four-state sequencer walks the slots in a fixed order: emit T_i, emit the half-fixed pattern, emit the one-bit-inserted pattern, then advance the register. The advance slot emits nothing, so valid is low for that beat. The generator and the insertion logic therefore act in separate beats of a single clock. The step enable plays the part of the two non-overlapping phases.

The output is a valid/ready stream held in a register. A pattern stays on the output, unchanged, until the consumer takes it with ready high. The sequencer steps only when step enable is high and the output register is empty or being emptied in that cycle. While the consumer stalls, neither the sequencer nor the register moves. When a pattern is taken while step enable is low, valid drops and the data stays where it is.

Top module: `lt_pattern_inserter`

## Requirements
- R1: After reset, pat_valid is low and pat_data is all zeros. The first pattern to appear after reset is the seed, with no bits changed.
- R2: Each group of four steps runs the slots in a fixed order: T_i, half-fixed, one-bit-inserted, advance. A step in the advance slot leaves pat_valid low. The step after it emits T_i+1.
- R3: The half-fixed pattern carries bits [W-1:W/2] from T_i and bits [W/2-1:0] from T_i+1.
- R4: The one-bit-inserted pattern equals the half-fixed pattern except at bit INS_BIT, which takes its value from T_i+1. It therefore differs from the half-fixed pattern in at most one bit.
- R5: The generator computes T_i+1 as {T_i[W-2:0], parity of (T_i AND TAPS)}. It changes only in the advance slot.
- R6: While pat_valid is high and pat_ready is low, pat_valid stays high and pat_data stays unchanged.
- R7: While step_en is low, pat_data and the sequencer hold their values. pat_valid falls if the held pattern is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_en | input | 1 | Lets the sequencer advance one slot |
| pat_ready | input | 1 | Consumer accepts the current pattern |
| pat_valid | output | 1 | pat_data holds a pattern |
| pat_data | output | W | Test pattern toward the circuit under test |

## Verification
A sequencer in the wrong state shows up within one step as the wrong kind of pattern. For example, a full pattern could appear where the half-fixed one belongs, or valid could be missing from a beat that should carry data. A generator that advances in the wrong slot, or with a wrong tap, shows up in the lower half of the next half-fixed pattern. That pattern appears two steps later. A wrong insertion bit shows up on the third step of the group, but only when that bit differs between T_i and T_i+1. The vectors are therefore chosen so that the inserted bit both sets and clears.

// File: rtl/ltpi_pkg.sv
package ltpi_pkg;
  typedef enum logic [1:0] {
    SL_EMIT  = 2'd0,
    SL_SPLIT = 2'd1,
    SL_FLIP  = 2'd2,
    SL_SHIFT = 2'd3
  } slot_e;
endpackage

// File: rtl/ltpi_gen.sv
module ltpi_gen #(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] cur,
  output logic [W-1:0] nxt
);
  logic fb;

  assign fb  = ^(cur & TAPS);
  assign nxt = {cur[W-2:0], fb};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cur <= SEED;
    else if (adv) cur <= nxt;
  end
endmodule

// File: rtl/ltpi_seq.sv
module ltpi_seq
  import ltpi_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  go,
  output slot_e slot,
  output logic  adv
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) slot <= SL_EMIT;
    else if (go) begin
      unique case (slot)
        SL_EMIT:  slot <= SL_SPLIT;
        SL_SPLIT: slot <= SL_FLIP;
        SL_FLIP:  slot <= SL_SHIFT;
        default:  slot <= SL_EMIT;
      endcase
    end
  end

  assign adv = go && (slot == SL_SHIFT);
endmodule

// File: rtl/ltpi_mix.sv
module ltpi_mix
  import ltpi_pkg::*;
#(
  parameter int W       = 8,
  parameter int INS_BIT = W / 2
) (
  input  slot_e        slot,
  input  logic [W-1:0] cur,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] mix
);
  localparam int H = W / 2;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i < H) begin : g_low
      // lower half follows the coming pattern in every intermediate slot
      assign mix[i] = (slot == SL_EMIT) ? cur[i] : nxt[i];
    end else if (i == INS_BIT) begin : g_ins
      assign mix[i] = (slot == SL_FLIP) ? nxt[i] : cur[i];
    end else begin : g_high
      assign mix[i] = cur[i];
    end
  end
endmodule

// File: rtl/lt_pattern_inserter.sv
module lt_pattern_inserter
  import ltpi_pkg::*;
#(
  parameter int W = 8,
  parameter logic [W-1:0] TAPS = 8'hB8,
  parameter logic [W-1:0] SEED = 8'h01,
  parameter int INS_BIT = W / 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step_en,
  input  logic         pat_ready,
  output logic         pat_valid,
  output logic [W-1:0] pat_data
);
  logic         step;
  logic         adv;
  slot_e        slot_q;
  logic [W-1:0] cur;
  logic [W-1:0] nxt;
  logic [W-1:0] mix;

  assign step = step_en && (!pat_valid || pat_ready);

  ltpi_seq u_seq (
    .clk  (clk),
    .rst_n(rst_n),
    .go   (step),
    .slot (slot_q),
    .adv  (adv)
  );

  ltpi_gen #(.W(W), .TAPS(TAPS), .SEED(SEED)) u_gen (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (adv),
    .cur  (cur),
    .nxt  (nxt)
  );

  ltpi_mix #(.W(W), .INS_BIT(INS_BIT)) u_mix (
    .slot(slot_q),
    .cur (cur),
    .nxt (nxt),
    .mix (mix)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pat_valid <= 1'b0;
      pat_data  <= '0;
    end else if (step) begin
      pat_valid <= (slot_q != SL_SHIFT);
      if (slot_q != SL_SHIFT) pat_data <= mix;
    end else if (pat_ready) begin
      pat_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/lt_pattern_inserter_chk.sv
module lt_pattern_inserter_chk
  import ltpi_pkg::*;
#(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         step_en,
  input logic         pat_ready,
  input logic         pat_valid,
  input logic [W-1:0] pat_data,
  input slot_e        slot_q,
  input logic         step
);
  localparam int H = W / 2;

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_valid && !pat_ready) |=> (pat_valid && $stable(pat_data)));

  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !step_en |=> ($stable(pat_data) && $stable(slot_q)));

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && slot_q == SL_EMIT) |=> (slot_q == SL_SPLIT));

  p_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && slot_q == SL_SHIFT) |=> !pat_valid);

  p_split_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && slot_q == SL_SPLIT) |=> (pat_data[W-1:H] == $past(pat_data[W-1:H])));

  p_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && slot_q == SL_FLIP) |=> ($countones(pat_data ^ $past(pat_data)) <= 1));
endmodule

bind lt_pattern_inserter lt_pattern_inserter_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .step_en  (step_en),
  .pat_ready(pat_ready),
  .pat_valid(pat_valid),
  .pat_data (pat_data),
  .slot_q   (slot_q),
  .step     (step)
);

// File: tb/lt_pattern_inserter_bench.sv
module lt_pattern_inserter_bench;
  localparam int W = 8;
  localparam int NV = 29;

  // entry = {tag[1:0], step_en, pat_ready, exp_valid, exp_data[7:0]}
  // tag: 0 -> R2, 1 -> R3, 2 -> R4, 3 -> R7
  localparam logic [12:0] VEC [NV] = '{
    13'h0701, 13'h0F02, 13'h1702, 13'h0602, 13'h0702, 13'h1A02,
    13'h0F04, 13'h1704, 13'h0604, 13'h0704, 13'h0F08, 13'h1708,
    13'h0608, 13'h0708, 13'h0F01, 13'h1711, 13'h0611, 13'h0711,
    13'h0F13, 13'h1703, 13'h0603, 13'h0723, 13'h0F27, 13'h1727,
    13'h0627, 13'h0747, 13'h0F4E, 13'h174E, 13'h064E
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         step_en = 1'b0;
  logic         pat_ready = 1'b0;
  logic         pat_valid;
  logic [W-1:0] pat_data;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  lt_pattern_inserter u_lt_pattern_inserter (
    .clk      (clk),
    .rst_n    (rst_n),
    .step_en  (step_en),
    .pat_ready(pat_ready),
    .pat_valid(pat_valid),
    .pat_data (pat_data)
  );

  task automatic check(input string req, input logic ev, input logic [W-1:0] ed);
    n_chk++;
    if (pat_valid !== ev || pat_data !== ed) begin
      n_bad++;
      $display("FAIL %s: valid=%0b data=%02h expected valid=%0b data=%02h",
               req, pat_valid, pat_data, ev, ed);
    end
  endtask

  task automatic beat(input logic e, input logic r);
    step_en   = e;
    pat_ready = r;
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    string tag;
    @(negedge clk);
    @(negedge clk);
    check("R1", 1'b0, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      case (VEC[i][12:11])
        2'd0: tag = "R2";
        2'd1: tag = "R3";
        2'd2: tag = "R4";
        default: tag = "R7";
      endcase
      beat(VEC[i][10], VEC[i][9]);
      check(tag, VEC[i][8], VEC[i][7:0]);
    end

    // generator holds 8E; stalled consumer
    beat(1'b1, 1'b0);
    check("R2", 1'b1, 8'h8E);
    for (int k = 0; k < 3; k++) begin
      beat(1'b1, 1'b0);
      check("R6", 1'b1, 8'h8E);
    end
    // next of 8E is 1C: half-fixed = 8C
    beat(1'b1, 1'b1);
    check("R5", 1'b1, 8'h8C);
    for (int k = 0; k < 2; k++) begin
      beat(1'b0, 1'b0);
      check("R7", 1'b1, 8'h8C);
    end

    // reset mid-stream
    rst_n = 1'b0;
    step_en = 1'b0;
    @(negedge clk);
    check("R1", 1'b0, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    beat(1'b1, 1'b1);
    check("R1", 1'b1, 8'h01);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule